// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This block collects the interrupt-worthy events of an Ethernet MAC into a 32-bit event word and gates them with a 32-bit enable mask. Each of thirteen implemented events has its own interrupt output line. There is no single combined interrupt. A fixed table chooses which event bit drives which line, and the table does not follow the bit order.

The MAC's internal logic reports an event with a one-cycle pulse on one bit of `evt_pulse`. The event bit stays set until software clears it by writing a 1 to it. Software reads and writes the event word and the mask word through a simple register bus. The bus has a write strobe, a read strobe, an address, write data and registered read data.

An interrupt line is high while its event bit and its mask bit are both set. Each line is a flop that is loaded only when its masked value changes. A line reflects a pulse or a register write at the same clock edge that updates the registers.

Top module: `eth_irq_fanout`

## Requirements
- R1: A 1 on `evt_pulse[k]` (k = 0..12) at a rising edge sets event bit 19+k. Bit 31 is heartbeat, 30 babbling-receive, 29 babbling-transmit, 28 graceful-stop-complete, 27 transmit-frame, 26 transmit-buffer, 25 receive-frame, 24 receive-buffer, 23 management-done, 22 bus-error, 21 late-collision, 20 retry-limit and 19 underrun. The event word is read at address 0x004.
- R2: Line i of `irq_lines` is driven by this event bit: line 0 by bit 27, 1 by 26, 2 by 19, 3 by 20, 4 by 25, 5 by 24, 6 by 23, 7 by 21, 8 by 31, 9 by 28, 10 by 22, 11 by 29 and 12 by 30.
- R3: A write to address 0x004 clears each event bit that is 1 in `bus_wdata` and leaves every other bit as it was.
- R4: The mask word at address 0x008 is a plain 32-bit read/write register.
- R5: After every clock edge, each line equals the AND of its event bit and its mask bit, both taken after that edge. A pulse or a write is therefore visible on the lines after the same edge that stores it.
- R6: When a pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R7: Event bits 18..0 can never be set and always read as 0.
- R8: A synchronous active-high reset clears the event word, the mask word, all lines and the read data.
- R9: A write to any address other than 0x004 or 0x008 changes nothing. A read of any such address returns 0.
- R10: `bus_rdata` is loaded at the edge where `bus_rd` is sampled high, with the register value from before that edge. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (10) | Register byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| evt_pulse | input | 13 | One-cycle event pulses, bit k sets event bit 19+k |
| irq_lines | output | 13 | Per-event interrupt lines, active high |

## Verification
The bench drives a pulse and a clearing write at the same bit in the same cycle. A design that let the clear win would drop the event, and the line would stay low. Single-bit pulses under a full mask walk every line through the mapping table. A table entry that was swapped or taken in bit order would raise the wrong line. Writes to unmapped addresses and to the low event bits are followed by reads. These show any decode leak into the mask or any bit that should not exist. Long random runs of mixed pulses, masks and clears catch a line that lags its masked state by a cycle or misses a change.

// File: rtl/evfan_pkg.sv
package evfan_pkg;
  localparam int NUM_EV = 13;

  // event index (bit position minus the lowest implemented bit) feeding line i
  function automatic int line_src(input int i);
    case (i)
      0:  line_src = 8;   // transmit-frame
      1:  line_src = 7;   // transmit-buffer
      2:  line_src = 0;   // underrun
      3:  line_src = 1;   // retry-limit
      4:  line_src = 6;   // receive-frame
      5:  line_src = 5;   // receive-buffer
      6:  line_src = 4;   // management-done
      7:  line_src = 2;   // late-collision
      8:  line_src = 12;  // heartbeat
      9:  line_src = 9;   // graceful-stop
      10: line_src = 3;   // bus-error
      11: line_src = 10;  // babbling-transmit
      default: line_src = 11; // babbling-receive
    endcase
  endfunction
endpackage

// File: rtl/evfan_event_reg.sv
module evfan_event_reg #(
  parameter int NUM_EV = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [NUM_EV-1:0] clr_val,
  input  logic [NUM_EV-1:0] set_pulse,
  output logic [NUM_EV-1:0] ev_q,
  output logic [NUM_EV-1:0] ev_next
);
  for (genvar b = 0; b < NUM_EV; b++) begin : g_bit
    // a hardware set overrides a clearing write on the same bit
    assign ev_next[b] = set_pulse[b] | (ev_q[b] & ~(clr_en & clr_val[b]));
    always_ff @(posedge clk) begin
      if (rst) ev_q[b] <= 1'b0;
      else     ev_q[b] <= ev_next[b];
    end
  end
endmodule

// File: rtl/evfan_mask_reg.sv
module evfan_mask_reg #(
  parameter int DATA_W = 32,
  parameter int NUM_EV = 13,
  localparam int LO    = DATA_W - NUM_EV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [NUM_EV-1:0] mask_hi_next
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end
  assign mask_hi_next = wr_en ? wdata[LO +: NUM_EV] : mask_q[LO +: NUM_EV];
endmodule

// File: rtl/evfan_line_drv.sv
module evfan_line_drv
  import evfan_pkg::*;
#(
  parameter int NUM_LINES = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EV-1:0]    masked_next,
  output logic [NUM_LINES-1:0] lines
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int SRC = line_src(i);
    logic changed;
    assign changed = masked_next[SRC] ^ lines[i];
    // each line flop loads only when its own masked value moved
    always_ff @(posedge clk) begin
      if (rst)          lines[i] <= 1'b0;
      else if (changed) lines[i] <= masked_next[SRC];
    end
  end
endmodule

// File: rtl/eth_irq_fanout.sv
module eth_irq_fanout
  import evfan_pkg::*;
#(
  parameter int DATA_W            = 32,
  parameter int ADDR_W            = 10,
  parameter logic [ADDR_W-1:0] EV_ADDR   = 10'h004,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 10'h008,
  localparam int EV_LO            = DATA_W - NUM_EV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EV-1:0] evt_pulse,
  output logic [NUM_EV-1:0] irq_lines
);
  logic              ev_hit, mask_hit;
  logic [NUM_EV-1:0] ev_q, ev_next, mask_hi_next;
  logic [DATA_W-1:0] ev_word, mask_word, rd_mux;

  assign ev_hit   = bus_addr == EV_ADDR;
  assign mask_hit = bus_addr == MASK_ADDR;

  evfan_event_reg #(.NUM_EV(NUM_EV)) u_ev (
    .clk(clk), .rst(rst),
    .clr_en(bus_wr & ev_hit),
    .clr_val(bus_wdata[EV_LO +: NUM_EV]),
    .set_pulse(evt_pulse),
    .ev_q(ev_q), .ev_next(ev_next)
  );

  evfan_mask_reg #(.DATA_W(DATA_W), .NUM_EV(NUM_EV)) u_mask (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr & mask_hit),
    .wdata(bus_wdata),
    .mask_q(mask_word), .mask_hi_next(mask_hi_next)
  );

  evfan_line_drv #(.NUM_LINES(NUM_EV)) u_lines (
    .clk(clk), .rst(rst),
    .masked_next(ev_next & mask_hi_next),
    .lines(irq_lines)
  );

  assign ev_word = {ev_q, {EV_LO{1'b0}}};

  always_comb begin
    if (ev_hit)        rd_mux = ev_word;
    else if (mask_hit) rd_mux = mask_word;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/eth_irq_fanout_chk.sv
module eth_irq_fanout_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int NUM_EV = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_EV-1:0] evt_pulse,
  input logic [NUM_EV-1:0] irq_lines,
  input logic [DATA_W-1:0] ev_word,
  input logic [DATA_W-1:0] mask_word
);
  localparam int LO = DATA_W - NUM_EV;

  // R6 and R1: a pulse always leaves its bit set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((ev_word[LO +: NUM_EV] & $past(evt_pulse)) == $past(evt_pulse)));

  // R3: cleared bits without a simultaneous pulse end up zero
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 10'h004) |=>
      ((ev_word[LO +: NUM_EV] & $past(bus_wdata[LO +: NUM_EV]) & ~$past(evt_pulse)) == '0));

  // R4: mask write takes the written value
  a_r4_mask_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 10'h008) |=> (mask_word == $past(bus_wdata)));

  // R5: number of raised lines matches the number of enabled pending events
  a_r5_line_count: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_lines) == $countones(ev_word & mask_word));

  // R2: heartbeat drives line 8
  a_r2_heartbeat_line: assert property (@(posedge clk) disable iff (rst)
    irq_lines[8] == (ev_word[31] && mask_word[31]));

  // R7: low event bits read back as zero
  a_r7_low_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 10'h004) |=> (bus_rdata[LO-1:0] == '0));

  // R8: the cycle after reset everything is quiet
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq_lines == '0 && ev_word == '0 && mask_word == '0 && bus_rdata == '0));

  // R10: read data holds without a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind eth_irq_fanout eth_irq_fanout_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EV(13)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
  .irq_lines(irq_lines), .ev_word(ev_word), .mask_word(mask_word)
);

// File: tb/tb_eth_irq_fanout.sv
module tb_eth_irq_fanout;
  localparam logic [9:0] A_EV = 10'h004, A_MASK = 10'h008;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [12:0] evt_pulse = '0, irq_lines;

  int checks = 0, errors = 0;
  logic [31:0] m_ev = '0, m_mask = '0, m_rdata = '0;
  int src_bit[13];

  always #10 clk = ~clk;

  eth_irq_fanout dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq_lines(irq_lines)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_lines();
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = m_ev[src_bit[i]] & m_mask[src_bit[i]];
    return r;
  endfunction

  // drive at a falling edge, update the model at the rising edge, compare at the next fall
  task automatic step(input string tag, input logic wr, input logic [9:0] a,
                      input logic [31:0] d, input logic rd, input logic [12:0] p);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd; evt_pulse = p;
    @(posedge clk);
    if (rd) m_rdata = (a == A_EV) ? m_ev : (a == A_MASK) ? m_mask : 32'h0;
    if (wr && a == A_EV)   m_ev = m_ev & ~d;
    if (wr && a == A_MASK) m_mask = d;
    m_ev = m_ev | (32'(p) << 19);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; evt_pulse = '0;
    check({tag, " R2/R5 lines"}, 32'(irq_lines), 32'(exp_lines()));
    check({tag, " R10 rdata"}, bus_rdata, m_rdata);
  endtask

  initial begin
    src_bit = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 lines after reset", 32'(irq_lines), 32'h0);
    check("R8 rdata after reset", bus_rdata, 32'h0);
    step("R8", 1'b0, A_EV, 32'h0, 1'b1, '0);
    step("R8", 1'b0, A_MASK, 32'h0, 1'b1, '0);
    // R4 mask read/write
    step("R4", 1'b1, A_MASK, 32'hA5A5_5A5A, 1'b0, '0);
    step("R4", 1'b0, A_MASK, 32'h0, 1'b1, '0);
    step("R4", 1'b1, A_MASK, 32'hFFFF_FFFF, 1'b1, '0);
    step("R4", 1'b0, A_MASK, 32'h0, 1'b1, '0);
    // R1 and R2: one pulse at a time walks every line
    for (int k = 0; k < 13; k++) begin
      step("R1", 1'b0, A_EV, 32'h0, 1'b0, 13'(1 << k));
      step("R1", 1'b0, A_EV, 32'h0, 1'b1, '0);
      step("R3", 1'b1, A_EV, 32'hFFFF_FFFF, 1'b0, '0);
    end
    // R3 partial clear
    step("R1", 1'b0, A_EV, 32'h0, 1'b0, 13'h1FFF);
    step("R3", 1'b1, A_EV, 32'h5A00_0000, 1'b0, '0);
    step("R3", 1'b0, A_EV, 32'h0, 1'b1, '0);
    // R6 set beats clear on the same bit
    step("R6", 1'b1, A_EV, 32'hFFFF_FFFF, 1'b0, 13'h1001);
    step("R6", 1'b0, A_EV, 32'h0, 1'b1, '0);
    // R7 low bits never appear
    step("R7", 1'b1, A_EV, 32'h0007_FFFF, 1'b1, 13'h1FFF);
    step("R7", 1'b0, A_EV, 32'h0, 1'b1, '0);
    // R9 unmapped addresses
    step("R9", 1'b1, 10'h00C, 32'h0, 1'b0, '0);
    step("R9", 1'b1, 10'h000, 32'hFFFF_FFFF, 1'b1, '0);
    step("R9", 1'b0, 10'h00C, 32'h0, 1'b1, '0);
    step("R9", 1'b0, A_MASK, 32'h0, 1'b1, '0);
    step("R9", 1'b0, A_EV, 32'h0, 1'b1, '0);
    // R5 random mix
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 5);
      logic [9:0] a = (sel < 2) ? A_EV : (sel < 4) ? A_MASK : 10'h010;
      step("R5", $urandom_range(0, 3) == 0, a, $urandom, $urandom_range(0, 1) == 1,
           13'($urandom & $urandom & $urandom));
    end
    // R8 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_ev = '0; m_mask = '0; m_rdata = '0;
    check("R8 lines after second reset", 32'(irq_lines), 32'h0);
    step("R8", 1'b0, A_MASK, 32'h0, 1'b1, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule